// File: doc/BRIEF.md
# Conditional Writeback Enable Unit

Each instruction of a small 8-bit core carries a condition. This unit works out that condition for the instruction currently in execute and uses the result to gate writeback. One source is chosen from a condition field. A negate bit can invert it, and the result becomes a single valid bit. That bit allows the carry, sign and zero flags to update. It also enables a one-hot decoder that write-enables the one destination register named by the instruction, out of eight.

There are two groups of sources. The basic sources are the constant Always and the C, S and Z flags. The extended sources are four user bits. Each user bit is fed from one of eight external wires, and a small selector register picks which wire. Every user bit is captured on a clock edge before it is evaluated, so a wire that changes mid-cycle cannot race the decision. The extended sources can be reached only from the register-register instruction form, which has a 4-bit condition field. The immediate form has three condition bits and reaches only the basic sources. A negated Always acts as Never.

Top module: `cwe_unit`

## Requirements
- R1: With `instr_valid` high and a basic source index of 0 (Always), the condition is true when `cond_negate` is 0 and false (Never) when it is 1.
- R2: Basic source index `cond_code[1:0]` values 1, 2 and 3 select `flag_c`, `flag_s` and `flag_z`. The condition is the selected flag XOR `cond_negate`.
- R3: In the register-register form (`reg_form`=1), `cond_code[3]`=1 selects user bit `cond_code[1:0]`. The condition is that bit XOR `cond_negate`.
- R4: In the immediate form (`reg_form`=0), `cond_code[3]` has no effect and only basic sources are selected. `cond_code[2]` has no effect in either form.
- R5: A user bit holds the value its selected wire had at the previous rising clock edge. A wire change between edges does not alter the condition until the next edge.
- R6: When `bsel_we` is high at a rising edge, the selector of user bit `bsel_idx` loads `bsel_src`, which is a wire number 0 to 7. The new selector is used from the next capture onward. After reset, user bit i selects wire i and every user bit reads 0.
- R7: `flag_upd_en` equals the condition result while `instr_valid` is high and reset is released.
- R8: When the condition is true and `instr_valid` is high, `reg_we` has exactly bit `dest_idx` set. When the condition is false, `reg_we` is all zero.
- R9: When `instr_valid` is low, `flag_upd_en` and `reg_we` are all zero, whatever the condition.
- R10: While `rst_n` is low, `flag_upd_en` and `reg_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is in execute |
| cond_code | input | 4 | Condition field; bit 3 selects user bits in the register-register form |
| cond_negate | input | 1 | Inverts the selected source |
| reg_form | input | 1 | 1 = register-register form, 0 = immediate form |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| user_wires | input | 8 | External wires that can feed the user bits |
| bsel_we | input | 1 | Load one user-bit selector |
| bsel_idx | input | 2 | Which user bit's selector to load |
| bsel_src | input | 3 | Wire number to load into the selector |
| dest_idx | input | 3 | Destination register index |
| flag_upd_en | output | 1 | Flag update enable |
| reg_we | output | 8 | One-hot register write enables |

## Verification
The enables are combinational in the instruction fields and flags, so they are due in the same cycle as the stimulus. A user bit lags its wire by one rising edge. A selector write needs one edge to load and one more to capture through the new selector, so it reaches the condition two edges after `bsel_we` is sampled. The bench drives inputs on the falling edge and compares both outputs with a behavioural model 5 ns later. That model holds the captured bits and selectors, updated at the rising edges, so every latency is taken into account in every cycle.

// File: rtl/cwe_pkg.sv
package cwe_pkg;

    localparam int unsigned COND_W = 4;

    typedef enum logic [1:0] {
        SRC_ALWAYS = 2'd0,
        SRC_CARRY  = 2'd1,
        SRC_SIGN   = 2'd2,
        SRC_ZERO   = 2'd3
    } basic_src_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
    } flags_t;

endpackage

// File: rtl/cwe_bit_capture.sv
module cwe_bit_capture #(
    parameter int unsigned USER_BITS = 4,
    parameter int unsigned WIRES     = 8,
    localparam int unsigned SEL_W    = $clog2(WIRES),
    localparam int unsigned IDX_W    = $clog2(USER_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [WIRES-1:0]     wires,
    output logic [USER_BITS-1:0] bits
);

    typedef struct packed {
        logic [USER_BITS-1:0][SEL_W-1:0] sel;
        logic [USER_BITS-1:0]            bits;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < USER_BITS; i++) begin
            st_d.bits[i] = wires[st_q.sel[i]];
        end
        if (cfg_we) begin
            st_d.sel[cfg_idx] = cfg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < USER_BITS; i++) begin
                st_q.sel[i] <= SEL_W'(i);
            end
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;

    for (genvar g = 0; g < USER_BITS; g++) begin : g_chk
        // R5
        bit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> bits[g] == $past(wires[st_q.sel[g]]));
        // R6
        sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == IDX_W'(g)) |=> st_q.sel[g] == $past(cfg_sel));
    end

endmodule

// File: rtl/cwe_cond_eval.sv
module cwe_cond_eval
    import cwe_pkg::*;
#(
    parameter int unsigned USER_BITS = 4,
    localparam int unsigned IDX_W    = $clog2(USER_BITS)
) (
    input  logic [COND_W-1:0]    code,
    input  logic                 negate,
    input  logic                 reg_form,
    input  flags_t               flags,
    input  logic [USER_BITS-1:0] user_bits,
    output logic                 cond
);

    logic       ext_sel;
    logic       basic_val;
    logic       src_val;
    basic_src_e basic_idx;

    always_comb begin
        ext_sel   = reg_form & code[COND_W-1];
        basic_idx = basic_src_e'(code[1:0]);
        unique case (basic_idx)
            SRC_ALWAYS: basic_val = 1'b1;
            SRC_CARRY:  basic_val = flags.c;
            SRC_SIGN:   basic_val = flags.s;
            SRC_ZERO:   basic_val = flags.z;
            default:    basic_val = 1'b1;
        endcase
        src_val = ext_sel ? user_bits[code[IDX_W-1:0]] : basic_val;
        cond    = src_val ^ negate;
    end

endmodule

// File: rtl/cwe_dest_decoder.sv
module cwe_dest_decoder #(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                en,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] we
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_we
        assign we[k] = en && (idx == IDX_W'(k));
    end

endmodule

// File: rtl/cwe_unit.sv
module cwe_unit
    import cwe_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned USER_BITS = 4,
    parameter int unsigned WIRES     = 8,
    localparam int unsigned DEST_W   = $clog2(NUM_REGS),
    localparam int unsigned SEL_W    = $clog2(WIRES),
    localparam int unsigned UIDX_W   = $clog2(USER_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [COND_W-1:0]   cond_code,
    input  logic                cond_negate,
    input  logic                reg_form,
    input  logic                flag_c,
    input  logic                flag_s,
    input  logic                flag_z,
    input  logic [WIRES-1:0]    user_wires,
    input  logic                bsel_we,
    input  logic [UIDX_W-1:0]   bsel_idx,
    input  logic [SEL_W-1:0]    bsel_src,
    input  logic [DEST_W-1:0]   dest_idx,
    output logic                flag_upd_en,
    output logic [NUM_REGS-1:0] reg_we
);

    logic [USER_BITS-1:0] user_bits;
    logic                 cond;
    logic                 wb_en;
    flags_t               flags;

    assign flags = '{c: flag_c, s: flag_s, z: flag_z};

    cwe_bit_capture #(
        .USER_BITS (USER_BITS),
        .WIRES     (WIRES)
    ) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (bsel_we),
        .cfg_idx (bsel_idx),
        .cfg_sel (bsel_src),
        .wires   (user_wires),
        .bits    (user_bits)
    );

    cwe_cond_eval #(
        .USER_BITS (USER_BITS)
    ) i_eval (
        .code      (cond_code),
        .negate    (cond_negate),
        .reg_form  (reg_form),
        .flags     (flags),
        .user_bits (user_bits),
        .cond      (cond)
    );

    assign wb_en       = rst_n & instr_valid & cond;
    assign flag_upd_en = wb_en;

    cwe_dest_decoder #(
        .NUM_REGS (NUM_REGS)
    ) i_decoder (
        .en  (wb_en),
        .idx (dest_idx),
        .we  (reg_we)
    );

    // R8
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));
    // R8
    dest_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_en |-> reg_we[dest_idx]);
    // R7
    flag_vs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_en == (reg_we != '0));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (reg_we == '0 && !flag_upd_en));
    // R1
    always_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond_code[1:0] == 2'd0 && !(reg_form && cond_code[3]))
            |-> flag_upd_en == !cond_negate);

endmodule

// File: tb/test_cwe_unit.sv
module test_cwe_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [3:0] cond_code = '0;
    logic       cond_negate = 1'b0;
    logic       reg_form = 1'b0;
    logic       flag_c = 1'b0, flag_s = 1'b0, flag_z = 1'b0;
    logic [7:0] user_wires = '0;
    logic       bsel_we = 1'b0;
    logic [1:0] bsel_idx = '0;
    logic [2:0] bsel_src = '0;
    logic [2:0] dest_idx = '0;
    logic       flag_upd_en;
    logic [7:0] reg_we;

    int checks = 0;
    int failures = 0;

    logic [2:0] sel_m [4];
    logic       b_m   [4];

    always #10 clk = ~clk;

    cwe_unit i_cwe_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .cond_code(cond_code), .cond_negate(cond_negate), .reg_form(reg_form),
        .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
        .user_wires(user_wires), .bsel_we(bsel_we), .bsel_idx(bsel_idx),
        .bsel_src(bsel_src), .dest_idx(dest_idx),
        .flag_upd_en(flag_upd_en), .reg_we(reg_we)
    );

    // behavioural model of the captured user bits and their selectors
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                sel_m[i] = 3'(i);
                b_m[i]   = 1'b0;
            end
        end else begin
            for (int i = 0; i < 4; i++) b_m[i] = user_wires[sel_m[i]];
            if (bsel_we) sel_m[bsel_idx] = bsel_src;
        end
    end

    function automatic logic model_cond();
        logic src;
        if (reg_form && cond_code[3]) src = b_m[cond_code[1:0]];
        else begin
            case (cond_code[1:0])
                2'd0: src = 1'b1;
                2'd1: src = flag_c;
                2'd2: src = flag_s;
                default: src = flag_z;
            endcase
        end
        return rst_n && instr_valid && (src ^ cond_negate);
    endfunction

    task automatic check(input string tag);
        logic       e_f;
        logic [7:0] e_we;
        e_f  = model_cond();
        e_we = e_f ? (8'd1 << dest_idx) : 8'd0;
        checks++;
        if (flag_upd_en !== e_f || reg_we !== e_we) begin
            failures++;
            $display("FAIL %s: flag_upd_en=%b reg_we=%b expected flag_upd_en=%b reg_we=%b",
                     tag, flag_upd_en, reg_we, e_f, e_we);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] code, input logic neg,
                         input logic form, input logic [2:0] czs,
                         input logic [2:0] dst, input string tag);
        @(negedge clk);
        instr_valid = v; cond_code = code; cond_negate = neg; reg_form = form;
        {flag_c, flag_z, flag_s} = {czs[2], czs[0], czs[1]};
        dest_idx = dst;
        #5 check(tag);
    endtask

    task automatic write_sel(input logic [1:0] idx, input logic [2:0] src);
        @(negedge clk);
        bsel_we = 1'b1; bsel_idx = idx; bsel_src = src;
        @(negedge clk);
        bsel_we = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: enables stay low while reset is held
        drive(1, 4'd0, 0, 1, 3'b111, 3'd2, "R10");
        drive(1, 4'b1000, 1, 1, 3'b111, 3'd5, "R10");
        @(negedge clk) rst_n = 1'b1;
        // R6: reset values of user bits read 0
        drive(1, 4'b1000, 0, 1, 3'b000, 3'd1, "R6");

        for (int d = 0; d < 8; d++) begin
            drive(1, 4'd0, 0, 0, 3'b000, 3'(d), "R1");
            drive(1, 4'd0, 1, 1, 3'b111, 3'(d), "R1");
        end
        for (int s = 1; s < 4; s++)
            for (int f = 0; f < 8; f++)
                for (int n = 0; n < 2; n++)
                    drive(1, 4'(s), 1'(n), 1'(f & 1), 3'(f), 3'(s + f), "R2");

        // R4: bit 3 ignored in immediate form, bit 2 ignored in both
        user_wires = 8'h0F;
        drive(1, 4'b1010, 0, 0, 3'b010, 3'd3, "R4");
        drive(1, 4'b1000, 1, 0, 3'b000, 3'd4, "R4");
        drive(1, 4'b0111, 0, 1, 3'b001, 3'd6, "R4");
        drive(1, 4'b1100, 0, 0, 3'b000, 3'd0, "R4");

        // R3: user bits selected in register form
        for (int b = 0; b < 4; b++) begin
            drive(1, 4'(8 + b), 0, 1, 3'b000, 3'(b), "R3");
            drive(1, 4'(12 + b), 1, 1, 3'b111, 3'(7 - b), "R3");
        end

        // R5: change wires between edges; effect only after next edge
        @(negedge clk) user_wires = 8'hF0;
        #5 check("R5");
        for (int b = 0; b < 4; b++) begin
            drive(1, 4'(8 + b), 0, 1, 3'b000, 3'd2, "R5");
        end
        @(negedge clk) user_wires = 8'h05;
        #5 check("R5");
        drive(1, 4'b1000, 0, 1, 3'b000, 3'd7, "R5");
        drive(1, 4'b1001, 0, 1, 3'b000, 3'd7, "R5");

        // R6: remap selectors
        user_wires = 8'b1000_0000;
        write_sel(2'd2, 3'd7);
        drive(1, 4'b1010, 0, 1, 3'b000, 3'd1, "R6");
        drive(1, 4'b1010, 0, 1, 3'b000, 3'd1, "R6");
        write_sel(2'd0, 3'd6);
        user_wires = 8'b0100_0000;
        drive(1, 4'b1000, 0, 1, 3'b000, 3'd0, "R6");
        drive(1, 4'b1000, 0, 1, 3'b000, 3'd0, "R6");
        drive(1, 4'b1010, 0, 1, 3'b000, 3'd0, "R6");

        // R9: invalid instruction writes nothing
        drive(0, 4'd0, 0, 0, 3'b000, 3'd3, "R9");
        drive(0, 4'b1000, 1, 1, 3'b111, 3'd6, "R9");

        // R7 / R8: mixed traffic compared each cycle
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            bsel_we = ($urandom % 8) == 0;
            bsel_idx = 2'($urandom); bsel_src = 3'($urandom);
            user_wires = 8'($urandom);
            instr_valid = ($urandom % 6) != 0;
            cond_code = 4'($urandom); cond_negate = 1'($urandom);
            reg_form = 1'($urandom);
            {flag_c, flag_s, flag_z} = 3'($urandom);
            dest_idx = 3'($urandom);
            #5 check((k % 2) ? "R7" : "R8");
        end
        bsel_we = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule